// File: doc/BRIEF.md
# Two-Stage Sinc Decimation Filter

This block is the digital back end of a delta-sigma converter. It takes a one-bit modulator stream, qualified by a valid strobe, and maps each accepted bit to +1 or -1. The stream first passes through a fifth-order sinc decimator with a fixed ratio of 16. A third-order sinc decimator follows, with a ratio D set by a rate code. The block emits a signed word together with a one-cycle strobe at the output word rate. Both stages are built from plain integrator and comb sections. There are no coefficients, so the phase response is linear.

The output word rate is a base rate divided by D. The base rate is 3840 or 3200 words per second at the nominal master clock, and a one-bit base select chooses between them. The rate code k gives D = 2^k for k from 0 to 6, so D runs from 1 to 64. A code above 6 is treated as 6. With k = 0, the block runs at one of its two fastest rates. In that case the third-order stage is skipped and the fifth-order result is sent straight to the output. The block has no internal timebase, so all rates scale with the clock that paces the input strobe.

A change to the rate code or to the base select clears every integrator, comb and counter. The next three output words are then withheld while the filters refill. The same withholding applies after reset.

Top module: `sinc_decim`

## Requirements
- R1: A valid bit of 1 enters the filter as +1 and a bit of 0 enters as -1. Cycles with the valid strobe low are ignored, so inserting idle cycles does not change any output value.
- R2: The first stage is a fifth-order sinc decimator with ratio 16 and a DC gain of 16^5.
- R3: The second-stage ratio is D = 2^k for rate code k in 0..6, and codes 7 and above act as 6. The output word rate is 3840/D when base select is 0 and 3200/D when it is 1. Changing base select alone restarts the filter.
- R4: For an input stream that repeats every 16 bits and holds c ones per period, the settled output word is (2c-16)*D^3. This is the full-precision result (2c-16)*2^16*D^3 with its 16 least significant bits dropped, so the word is bits [39:16] of a 40-bit accumulator.
- R5: With rate code 0, the third-order stage is bypassed, and one word is produced for every 16 accepted input bits.
- R6: With rate code k > 0, one word is produced for every 16*D accepted input bits.
- R7: After a change of rate code or base select, all filter state is cleared. The first three words are then withheld, so no output strobe appears before 64*D input bits have been accepted since the change.
- R8: The output strobe is high for exactly one cycle per word, and the output data holds its value between strobes.
- R9: During reset the output strobe is 0 and the output data is 0. The first three words after reset are withheld, as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Modulator bit strobe |
| bit_in | input | 1 | Modulator bit, 1 maps to +1 and 0 maps to -1 |
| rate_code | input | 3 | Second-stage ratio exponent k, D = 2^k |
| base_sel | input | 1 | Base rate select, 0 for 3840 and 1 for 3200 |
| out_vld | output | 1 | One-cycle strobe per output word |
| out_data | output | 24 | Signed output word |

## Verification
A corrupted integrator or comb register does not fade away. Because integrators wrap and have no leak, the error shows up as a wrong settled word or as drift, starting with the first unwithheld word after the fault, at most 16*D input bits later. A wrong decimation counter changes the number of input bits between strobes, which is visible on the second word. A broken clear or a broken withholding count moves the first strobe after a rate change away from its position at 64*D accepted bits. The bench repeats stimulus with a 16-bit period so that every settled word can be predicted exactly.

// File: rtl/sinc_pkg.sv
// Package: shared helpers for the two-stage sinc decimator.
// Assumes rate codes are small unsigned exponents of two.
package sinc_pkg;

    // Base-rate selection: 0 picks the faster base, 1 the slower one.
    typedef enum logic {
        BASE_FAST = 1'b0,
        BASE_SLOW = 1'b1
    } base_e;

    // Clamp a rate code to the largest supported exponent.
    function automatic int unsigned clamp_code(input int unsigned code, input int unsigned max_code);
        return (code > max_code) ? max_code : code;
    endfunction

endpackage

// File: rtl/sinc_integ.sv
// Module: N cascaded wrapping integrators at the input rate.
// Assumes W covers input width plus N*log2(ratio) so the stage output is exact.
module sinc_integ #(
    parameter int N = 5,
    parameter int W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] acc [N];

    // Accumulate each section on enabled cycles; clear on reset or reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < N; i++) acc[i] <= '0;
        end else if (en) begin
            acc[0] <= acc[0] + din;
            for (int i = 1; i < N; i++) acc[i] <= acc[i] + acc[i-1];
        end
    end

    assign dout = acc[N-1];
endmodule

// File: rtl/sinc_comb.sv
// Module: N cascaded unit-delay comb sections at the decimated rate.
// Assumes en pulses once per decimated sample; wraps in two's complement.
module sinc_comb #(
    parameter int N = 5,
    parameter int W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] dly [N];
    logic signed [W-1:0] y   [N];

    // Pipelined differences: each section subtracts its previous input.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < N; i++) begin
                dly[i] <= '0;
                y[i]   <= '0;
            end
        end else if (en) begin
            y[0]   <= din - dly[0];
            dly[0] <= din;
            for (int i = 1; i < N; i++) begin
                y[i]   <= y[i-1] - dly[i];
                dly[i] <= y[i-1];
            end
        end
    end

    assign dout = y[N-1];
endmodule

// File: rtl/sinc_stage.sv
// Module: one sinc decimation stage (integrators, ratio counter, combs).
// Assumes ratio_m1 is held stable except across a clr pulse.
module sinc_stage #(
    parameter int N  = 5,
    parameter int W  = 22,
    parameter int CW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 in_vld,
    input  logic signed [W-1:0]  din,
    input  logic        [CW-1:0] ratio_m1,
    output logic signed [W-1:0]  dout,
    output logic                 out_vld
);
    logic signed [W-1:0] int_out;
    logic        [CW-1:0] cnt;
    logic                 fire;

    sinc_integ #(.N(N), .W(W)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(in_vld), .din(din), .dout(int_out)
    );

    // Count accepted samples and flag every ratio-th one for the comb side.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (in_vld) begin
                if (cnt == ratio_m1) begin
                    cnt  <= '0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    sinc_comb #(.N(N), .W(W)) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(fire), .din(int_out), .dout(dout)
    );

    // Mark the cycle in which the comb result is fresh.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) out_vld <= 1'b0;
        else               out_vld <= fire;
    end
endmodule

// File: rtl/sinc_rate_ctrl.sv
// Module: rate configuration, reconfiguration clear and output withholding.
// Assumes rate inputs are synchronous to clk.
module sinc_rate_ctrl #(
    parameter int CODE_W   = 3,
    parameter int DMAX_LOG = 6,
    parameter int SUP_N    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   rate_code,
    input  logic                base_sel,
    input  logic                evt,
    output logic                clr,
    output logic [DMAX_LOG-1:0] d_m1,
    output logic                bypass,
    output logic                pass
);
    import sinc_pkg::*;
    localparam int SUP_W = $clog2(SUP_N + 1);

    logic [CODE_W-1:0] cur_code;
    base_e             cur_base;
    logic [SUP_W-1:0]  sup;
    logic [CODE_W-1:0] eff;
    logic [DMAX_LOG:0] d_full;

    assign clr = ({rate_code, base_sel} != {cur_code, cur_base});

    // Latch the configuration and rearm the withholding count on any change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_code <= '0;
            cur_base <= BASE_FAST;
            sup      <= SUP_W'(SUP_N);
        end else if (clr) begin
            cur_code <= rate_code;
            cur_base <= base_e'(base_sel);
            sup      <= SUP_W'(SUP_N);
        end else if (evt && sup != '0) begin
            sup <= sup - 1'b1;
        end
    end

    // Derive the second-stage ratio from the clamped exponent.
    always_comb begin
        eff    = CODE_W'(clamp_code(int'(cur_code), DMAX_LOG));
        d_full = (DMAX_LOG+1)'(1) << eff;
        d_m1   = DMAX_LOG'(d_full - 1'b1);
        bypass = (eff == '0);
    end

    assign pass = evt && (sup == '0) && !clr;
endmodule

// File: rtl/sinc_decim.sv
// Module: two-stage sinc decimator top (order-5 by 16, then order-3 by D).
// Assumes a one-bit modulator stream; output is the top OUT_W bits of the
// full-precision second-stage accumulator.
module sinc_decim #(
    parameter  int R1_LOG   = 4,
    parameter  int N1       = 5,
    parameter  int N2       = 3,
    parameter  int DMAX_LOG = 6,
    parameter  int OUT_W    = 24,
    parameter  int SUP_N    = 3,
    localparam int CODE_W   = $clog2(DMAX_LOG + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic                    bit_in,
    input  logic [CODE_W-1:0]       rate_code,
    input  logic                    base_sel,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int IN_W = 2;
    localparam int W1   = IN_W + N1 * R1_LOG;
    localparam int W2   = W1 + N2 * DMAX_LOG;

    logic                    clr, bypass, pass, evt;
    logic [DMAX_LOG-1:0]     d_m1;
    logic signed [IN_W-1:0]  x;
    logic signed [W1-1:0]    x_ext, s1_out;
    logic signed [W2-1:0]    s1_ext, s2_out, full;
    logic                    s1_vld, s2_vld;

    assign x      = bit_in ? IN_W'(1) : '1;
    assign x_ext  = {{(W1-IN_W){x[IN_W-1]}}, x};
    assign s1_ext = {{(W2-W1){s1_out[W1-1]}}, s1_out};

    sinc_rate_ctrl #(.CODE_W(CODE_W), .DMAX_LOG(DMAX_LOG), .SUP_N(SUP_N)) u_rate (
        .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .base_sel(base_sel),
        .evt(evt), .clr(clr), .d_m1(d_m1), .bypass(bypass), .pass(pass)
    );

    sinc_stage #(.N(N1), .W(W1), .CW(R1_LOG)) u_stage1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .din(x_ext),
        .ratio_m1(R1_LOG'((1 << R1_LOG) - 1)), .dout(s1_out), .out_vld(s1_vld)
    );

    sinc_stage #(.N(N2), .W(W2), .CW(DMAX_LOG)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(s1_vld && !bypass), .din(s1_ext),
        .ratio_m1(d_m1), .dout(s2_out), .out_vld(s2_vld)
    );

    assign evt  = bypass ? s1_vld : s2_vld;
    assign full = bypass ? s1_ext : s2_out;

    // Register the truncated word when a result is allowed through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= pass;
            if (pass) out_data <= full[W2-1 -: OUT_W];
        end
    end
endmodule

// File: rtl/sinc_decim_chk.sv
// Module: assertion checker for sinc_decim, bound to every instance.
// Tracks accepted input bits since the last configuration change on its own.
module sinc_decim_chk #(
    parameter int CODE_W   = 3,
    parameter int DMAX_LOG = 6,
    parameter int OUT_W    = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic [CODE_W-1:0]       rate_code,
    input logic                    base_sel,
    input logic                    out_vld,
    input logic signed [OUT_W-1:0] out_data
);
    localparam int CNT_W = DMAX_LOG + 8;

    logic [CODE_W-1:0] prev_code;
    logic              prev_base;
    logic [CNT_W-1:0]  since;
    logic [CODE_W-1:0] eff;
    logic [CNT_W-1:0]  min_in;
    logic              chg;

    assign chg    = {rate_code, base_sel} != {prev_code, prev_base};
    assign eff    = (prev_code > CODE_W'(DMAX_LOG)) ? CODE_W'(DMAX_LOG) : prev_code;
    assign min_in = CNT_W'(64) << eff;

    // Count accepted bits since reset or the latest rate change (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_code <= '0;
            prev_base <= 1'b0;
            since     <= '0;
        end else if (chg) begin
            prev_code <= rate_code;
            prev_base <= base_sel;
            since     <= '0;
        end else if (in_vld && since != '1) begin
            since <= since + 1'b1;
        end
    end

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_data == '0));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

    assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_data));

    assert_withhold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (since >= min_in));
endmodule

bind sinc_decim sinc_decim_chk #(.CODE_W(CODE_W), .DMAX_LOG(DMAX_LOG), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .rate_code(rate_code), .base_sel(base_sel),
    .out_vld(out_vld), .out_data(out_data)
);

// File: tb/sim_sinc_decim.sv
// Bench: periodic 16-bit patterns, directed and seeded-random rate settings.
module sim_sinc_decim;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic              bit_in = 1'b0;
    logic [2:0]        rate_code = '0;
    logic              base_sel = 1'b0;
    logic              out_vld;
    logic signed [23:0] out_data;

    logic [15:0] pat = '0;
    logic [3:0]  pidx = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sinc_decim u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .bit_in(bit_in),
        .rate_code(rate_code), .base_sel(base_sel),
        .out_vld(out_vld), .out_data(out_data)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected settled word for a 16-bit periodic pattern and ratio d.
    function automatic int exp_word(input logic [15:0] p, input int d);
        return (2 * $countones(p) - 16) * d * d * d;
    endfunction

    // Drive one input cycle and sample outputs mid-cycle after the edge.
    task automatic step(input bit gaps, output logic ov, output logic signed [23:0] od);
        in_vld = gaps ? ($urandom % 4 != 0) : 1'b1;
        bit_in = pat[pidx];
        if (in_vld) pidx = pidx + 1'b1;
        @(posedge clk);
        #5;
        ov = out_vld;
        od = out_data;
    endtask

    task automatic run_case(input int code, input bit base, input logic [15:0] p,
                            input bit gaps, input string vtag);
        int eff  = (code > 6) ? 6 : code;
        int d    = 1 << eff;
        int expv = exp_word(p, d);
        int n    = 0;
        int nout = 0;
        int nsince = 0;
        int guard = 0;
        logic ov;
        logic signed [23:0] od;
        pat = p;
        pidx = '0;
        rate_code = 3'(code);
        base_sel = base;
        step(1'b0, ov, od);
        while (!ov && n < 64 * d + 40) begin
            step(1'b0, ov, od);
            if (in_vld) n++;
        end
        // R7: three words withheld, first strobe near 64*D accepted bits
        check(ov && n >= 64 * d && n <= 64 * d + 12, "R7", n, 64 * d);
        nout = 1;
        step(gaps, ov, od);
        if (in_vld) nsince++;
        check(!ov, "R8", int'(ov), 0);
        while (nout < 8 && guard < 40 * 16 * d + 200) begin
            guard++;
            step(gaps, ov, od);
            if (in_vld) nsince++;
            if (ov) begin
                nout++;
                if (nout == 8 && !gaps)
                    check(nsince == 16 * d, (d == 1) ? "R5" : "R6", nsince, 16 * d);
                nsince = 0;
                if (nout >= 7) check(od == expv, vtag, int'(od), expv);
            end
        end
        check(nout == 8, "R6", nout, 8);
    endtask

    initial begin
        logic [15:0] p;
        int c, pc;
        bit b, pb;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #5;
        // R9: quiet outputs while reset is held
        check(out_vld == 1'b0 && out_data == '0, "R9", int'(out_data), 0);
        rst_n = 1'b1;
        run_case(0, 1'b0, 16'hFFFF, 1'b0, "R2");       // R2, R9: bypass, full scale +
        run_case(6, 1'b1, 16'h0000, 1'b0, "R4");       // largest ratio, full scale -
        run_case(3, 1'b0, 16'hAAAA, 1'b0, "R4");       // zero-mean pattern
        run_case(0, 1'b1, 16'h7777, 1'b0, "R5");       // R5: bypass at the other base
        run_case(2, 1'b1, 16'h00FF, 1'b0, "R4");
        run_case(2, 1'b0, 16'h0F0F, 1'b0, "R3");       // R3: base change alone restarts
        run_case(7, 1'b0, 16'hFF0F, 1'b0, "R3");       // R3: code 7 clamps to D=64
        pc = 7;
        pb = 1'b0;
        for (int i = 0; i < 6; i++) begin
            do begin
                c = $urandom % 6;
                b = 1'($urandom % 2);
            end while (c == pc && b == pb);
            p = 16'($urandom);
            run_case(c, b, p, 1'b1, "R1");             // R1: idle gaps leave values intact
            pc = c;
            pb = b;
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule